// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides, on every oscillator cycle, whether a small microcontroller core and its peripherals receive a clock edge. The free-running oscillator is halved by a single toggle flop. That toggle produces one internal clock tick in every two oscillator cycles, so the duty cycle of the oscillator does not matter. The core receives the tick as a CPU clock enable. The timers, the serial port and the interrupt logic receive it as a peripheral clock enable.

Software asks for one of two sleep levels through two request inputs. In idle, the CPU enable stops and the peripheral enable keeps running. Idle ends when any bit of the interrupt request vector is high at a tick. In power-down, the divide stage is frozen, which models a stopped oscillator. Both enables stay low, interrupts have no effect, and only the hardware reset brings the block back to run. After every reset, a stabilisation counter models the time the oscillator needs to restart. The CPU enable stays low until that counter expires, and a reset-sequencing output is high during this wait.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` reads 00 (run), `rst_seq` is 1, and both `cpu_ce` and `per_ce` are 0.
- R2: After `rst_n` rises, `rst_seq` stays 1 for exactly STAB_CYCLES oscillator edges. `cpu_ce` is first high after edge STAB_CYCLES+1.
- R3: In run mode, `cpu_ce` and `per_ce` are one-cycle pulses on every second oscillator cycle, and are never high in two adjacent cycles.
- R4: If `idle_req` is high at a tick (a cycle with `per_ce` high) in run mode, `mode` becomes 01 after that edge. `cpu_ce` then stays low, and `per_ce` keeps pulsing every second cycle.
- R5: In idle, if any bit of `irq_req` is high at a tick, `mode` returns to 00 after that edge, and `cpu_ce` pulses again two cycles later.
- R6: If `pd_req` is high at a tick in run mode, `mode` becomes 10 after that edge. From then on `cpu_ce` and `per_ce` stay low, and `irq_req` and `idle_req` have no effect.
- R7: Power-down is left only by driving `rst_n` low. After reset, the block is in run mode and the restart delay of R2 applies again.
- R8: If `idle_req` and `pd_req` are both high at the same tick, power-down wins and `mode` becomes 10.
- R9: `idle_req` and `pd_req` are sampled only at a tick. A request that is high only in a non-tick cycle leaves `mode` at 00.
- R10: A reset asserted during idle returns `mode` to 00 and restarts the stabilisation delay of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running oscillator input; clocks all state |
| rst_n | input | 1 | Active-low hardware reset, sampled on `osc_clk` |
| idle_req | input | 1 | Software request to enter idle |
| pd_req | input | 1 | Software request to enter power-down |
| irq_req | input | N_IRQ | Enabled interrupt requests; any set bit wakes idle |
| cpu_ce | output | 1 | CPU clock enable (one pulse per internal clock) |
| per_ce | output | 1 | Peripheral clock enable |
| mode | output | 2 | Current mode: 00 run, 01 idle, 10 power-down |
| rst_seq | output | 1 | High while reset or oscillator stabilisation is in progress |

## Verification
The bench counts the edges between reset release and the first CPU pulse. A counter that is off by one, or a CPU enable that ignores the stabilisation flag, shows up as a wrong edge count. It places requests in tick and non-tick cycles. A design that samples requests at the oscillator rate would then sleep on a request it should have ignored. It asserts both requests at one tick, and it raises interrupts during power-down. A wrong priority, or a wake path that is not blocked in power-down, leaves the block in idle or returns it to run. It also resets the block from idle and from power-down, so that a restart delay that is skipped after the first reset is caught.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode clock controller.
// Assumes: the mode encoding is visible at the block's port, so the
// values are fixed and must not be reordered.
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_PDOWN = 2'b10
    } lpm_mode_e;

endpackage

// File: rtl/lpm_osc_stab.sv
// Oscillator restart model: counts STAB_CYCLES oscillator edges after reset
// release, then raises `stable` and holds it until the next reset.
// Assumes: rst_n is synchronous to osc_clk; STAB_CYCLES >= 1.
module lpm_osc_stab #(
    parameter int STAB_CYCLES = 16
) (
    input  logic osc_clk,
    input  logic rst_n,
    output logic stable
);
    localparam int CNT_W = $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count up after reset until the programmed wait has elapsed.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stable <= 1'b0;
        end else if (!stable) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                stable <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lpm_clk_div.sv
// Divide-by-two stage: a toggle flop that advances only while run_en is
// high. `tick` marks the one oscillator cycle of each internal clock period
// in which the downstream logic may act.
// Assumes: freezing the toggle models a stopped oscillator.
module lpm_clk_div (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic run_en,
    output logic tick
);
    logic phase_q;

    // Toggle the phase flop on every enabled oscillator edge.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (run_en) begin
            phase_q <= ~phase_q;
        end
    end

    assign tick = phase_q;

endmodule

// File: rtl/lpm_mode_fsm.sv
// Mode register: run, idle and power-down. Requests are sampled only at a
// tick. Power-down has priority over idle. Idle wakes on any interrupt.
// Power-down can only be left through reset.
// Assumes: tick never rises in power-down, because the divider is frozen.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      osc_clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      idle_req,
    input  logic      pd_req,
    input  logic      wake,
    output lpm_mode_e mode_q
);
    lpm_mode_e mode_d;

    // Next-mode decision, evaluated only at a tick.
    always_comb begin
        mode_d = mode_q;
        if (tick) begin
            unique case (mode_q)
                MODE_RUN: begin
                    if (pd_req) begin
                        mode_d = MODE_PDOWN;
                    end else if (idle_req) begin
                        mode_d = MODE_IDLE;
                    end
                end
                MODE_IDLE: begin
                    if (wake) begin
                        mode_d = MODE_RUN;
                    end
                end
                default: mode_d = mode_q;
            endcase
        end
    end

    // Mode state register with synchronous reset to run.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/lpm_clk_ctrl.sv
// Low-power mode clock controller top. It joins the restart counter, the
// divide-by-two stage and the mode register, and forms the CPU and
// peripheral clock enables.
// Assumes: rst_n is already synchronised to osc_clk; the clock enables are
// consumed by logic clocked on osc_clk.
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ       = 4,
    parameter int STAB_CYCLES = 16
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             idle_req,
    input  logic             pd_req,
    input  logic [N_IRQ-1:0] irq_req,
    output logic             cpu_ce,
    output logic             per_ce,
    output logic [1:0]       mode,
    output logic             rst_seq
);
    logic      stable;
    logic      tick;
    logic      run_en;
    logic      wake;
    lpm_mode_e mode_q;

    lpm_osc_stab #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .stable  (stable)
    );

    // The divider runs once the oscillator is stable, and not in power-down.
    assign run_en = stable && (mode_q != MODE_PDOWN);

    lpm_clk_div u_div (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .tick    (tick)
    );

    // Any set interrupt request is a wake event.
    assign wake = |irq_req;

    lpm_mode_fsm u_fsm (
        .osc_clk  (osc_clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .idle_req (idle_req),
        .pd_req   (pd_req),
        .wake     (wake),
        .mode_q   (mode_q)
    );

    // Enables: the CPU clock only in run, the peripheral clock in run and idle.
    assign cpu_ce  = tick && stable && (mode_q == MODE_RUN);
    assign per_ce  = tick && stable && (mode_q != MODE_PDOWN);
    assign mode    = mode_q;
    assign rst_seq = ~stable;

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
// Port-level checker for lpm_clk_ctrl, attached by bind.
// Assumes: rst_n is low at time zero.
module lpm_clk_ctrl_chk (
    input logic       osc_clk,
    input logic       rst_n,
    input logic       cpu_ce,
    input logic       per_ce,
    input logic [1:0] mode,
    input logic       rst_seq
);
    AST_CPU_ONLY_IN_RUN: assert property (@(posedge osc_clk) disable iff (!rst_n)
        cpu_ce |-> (mode == 2'b00 && per_ce));                          // R4
    AST_SEQ_GATES_CLOCKS: assert property (@(posedge osc_clk) disable iff (!rst_n)
        rst_seq |-> (!cpu_ce && !per_ce));                              // R2
    AST_PULSE_ALTERNATES: assert property (@(posedge osc_clk) disable iff (!rst_n)
        per_ce |=> !per_ce);                                            // R3
    AST_PDOWN_SILENT: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (!cpu_ce && !per_ce));                      // R6
    AST_PDOWN_STICKY: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (mode == 2'b10));                           // R7
    AST_IDLE_NOT_PDOWN: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (mode != 2'b10));                           // R6
    AST_MODE_LEGAL: assert property (@(posedge osc_clk) disable iff (!rst_n)
        mode != 2'b11);                                                 // R1
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .cpu_ce  (cpu_ce),
    .per_ce  (per_ce),
    .mode    (mode),
    .rst_seq (rst_seq)
);

// File: tb/sim_lpm_clk_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_clk_ctrl;
    localparam int N_IRQ = 4;
    localparam int STAB  = 16;

    logic             osc_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic             idle_req = 1'b0;
    logic             pd_req   = 1'b0;
    logic [N_IRQ-1:0] irq_req  = '0;
    logic             cpu_ce, per_ce, rst_seq;
    logic [1:0]       mode;

    int total = 0;
    int bad   = 0;

    always #2.5 osc_clk = ~osc_clk;

    lpm_clk_ctrl #(.N_IRQ(N_IRQ), .STAB_CYCLES(STAB)) u0 (
        .osc_clk (osc_clk), .rst_n (rst_n), .idle_req (idle_req),
        .pd_req (pd_req), .irq_req (irq_req), .cpu_ce (cpu_ce),
        .per_ce (per_ce), .mode (mode), .rst_seq (rst_seq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait in run mode until a tick cycle is visible at a falling edge.
    task automatic wait_tick();
        for (int i = 0; i < 8; i++) begin
            @(negedge osc_clk);
            if (cpu_ce) return;
        end
        chk("wait_tick", 0, 1);
    endtask

    // Release reset and measure the restart delay.
    task automatic release_and_measure(input string req);
        int seq_low_at = -1;
        int cpu_at = -1;
        @(negedge osc_clk);
        rst_n = 1'b1;
        for (int k = 1; k <= 4 * STAB; k++) begin
            @(negedge osc_clk);
            if (seq_low_at < 0 && !rst_seq) seq_low_at = k;
            if (cpu_at < 0 && cpu_ce) cpu_at = k;
            if (cpu_at >= 0) break;
        end
        chk({req, " rst_seq low edge"}, seq_low_at, STAB);
        chk({req, " first cpu_ce edge"}, cpu_at, STAB + 1);
        chk({req, " mode run"}, mode, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        chk("R1 mode", mode, 0);
        chk("R1 rst_seq", rst_seq, 1);
        chk("R1 cpu_ce", cpu_ce, 0);
        chk("R1 per_ce", per_ce, 0);
        release_and_measure("R2");
    endtask

    task automatic t_div();
        int highs = 0;
        int adj = 0;
        logic prev = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge osc_clk);
            if (cpu_ce) highs++;
            if (cpu_ce && prev) adj++;
            prev = cpu_ce;
        end
        chk("R3 pulses in 10 cycles", highs, 5);
        chk("R3 adjacent pulses", adj, 0);
    endtask

    task automatic t_idle();
        int cpu_hi = 0;
        int per_hi = 0;
        wait_tick();
        idle_req = 1'b1;
        @(negedge osc_clk);
        idle_req = 1'b0;
        chk("R4 mode idle", mode, 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge osc_clk);
            if (cpu_ce) cpu_hi++;
            if (per_ce) per_hi++;
        end
        chk("R4 cpu_ce in idle", cpu_hi, 0);
        chk("R4 per_ce pulses in idle", per_hi, 4);
        for (int i = 0; i < 4 && !per_ce; i++) @(negedge osc_clk);
        irq_req = 4'b0100;
        @(negedge osc_clk);
        irq_req = '0;
        chk("R5 mode after irq", mode, 0);
        @(negedge osc_clk);
        chk("R5 cpu_ce resumes", cpu_ce, 1);
    endtask

    task automatic t_gap();
        wait_tick();
        @(negedge osc_clk);
        idle_req = 1'b1;
        pd_req   = 1'b1;
        @(negedge osc_clk);
        idle_req = 1'b0;
        pd_req   = 1'b0;
        chk("R9 off-tick request ignored", mode, 0);
        @(negedge osc_clk);
        chk("R9 mode still run", mode, 0);
    endtask

    task automatic t_pd();
        int hi = 0;
        wait_tick();
        pd_req = 1'b1;
        @(negedge osc_clk);
        pd_req = 1'b0;
        chk("R6 mode power-down", mode, 2);
        irq_req  = '1;
        idle_req = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge osc_clk);
            if (cpu_ce || per_ce) hi++;
        end
        irq_req  = '0;
        idle_req = 1'b0;
        chk("R6 enables in power-down", hi, 0);
        chk("R7 stays power-down", mode, 2);
        rst_n = 1'b0;
        repeat (2) @(negedge osc_clk);
        chk("R7 reset gives run", mode, 0);
        release_and_measure("R7");
    endtask

    task automatic t_both();
        wait_tick();
        idle_req = 1'b1;
        pd_req   = 1'b1;
        @(negedge osc_clk);
        idle_req = 1'b0;
        pd_req   = 1'b0;
        chk("R8 power-down wins", mode, 2);
        rst_n = 1'b0;
        repeat (2) @(negedge osc_clk);
        release_and_measure("R8");
    endtask

    task automatic t_rst_idle();
        wait_tick();
        idle_req = 1'b1;
        @(negedge osc_clk);
        idle_req = 1'b0;
        chk("R10 idle entered", mode, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge osc_clk);
        chk("R10 mode run in reset", mode, 0);
        chk("R10 rst_seq in reset", rst_seq, 1);
        release_and_measure("R10");
    endtask

    initial begin
        t_reset();
        t_div();
        t_idle();
        t_gap();
        t_pd();
        t_both();
        t_rst_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge osc_clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule